// File: doc/BRIEF.md
# Jump Condition and Link Unit

This block settles every control transfer of a sign-magnitude accumulator machine except the input/output ones. For each jump request it says whether the jump is taken and where it goes. It also says whether the two-byte link register must be loaded with the return address, and whether the overflow status must be cleared. The execute stage supplies the jump variant, the current overflow and comparison status, the register file contents that a sign test may examine, the already-indexed effective address and the address of the following instruction.

Requests are flagged by a valid strobe. Results come out of one register stage a cycle later. The output strobes (taken, link write, overflow clear) are low in any cycle that does not follow a request. The tested register can be the accumulator, the extension register or any of the index registers. All of these are held as a sign bit above a magnitude, and a magnitude of zero is zero whatever its sign.

Top module: `jmp_cond_link`

## Requirements
- R1: With `grp_i`=0 and `fn_i`=0 (plain jump) the result is taken, `target_o` equals the effective address of the request and `link_val_o` equals its next-instruction address.
- R2: With `grp_i`=0 and `fn_i`=1 (jump without link) the result is taken and `link_we_o` stays low.
- R3: With `grp_i`=0 and `fn_i`=2 (jump on overflow) the result is taken exactly when `ovf_i` is 1, and `ovf_clr_o` is high exactly in that case.
- R4: With `grp_i`=0 and `fn_i`=3 (jump on no overflow) the result is taken exactly when `ovf_i` is 0, and `ovf_clr_o` is high exactly when `ovf_i` is 1.
- R5: With `grp_i`=0, `fn_i` codes 4..9 jump on less, equal, greater, greater-or-equal, not-equal and less-or-equal. Here `cmp_i` is 2'b01 for less, 2'b00 for equal and 2'b10 for greater. These jumps never raise `ovf_clr_o`.
- R6: With `grp_i`=1 the register chosen by `reg_sel_i` is tested: 0 is the accumulator, 1 the extension register, 2..7 index registers 1..6. `fn_i` codes 0..5 mean negative, zero, positive, non-negative, non-zero and non-positive. The sign bit is the MSB of each register port, with 1 meaning negative.
- R7: A register whose magnitude is zero is treated as zero with either sign bit, so minus zero passes the zero, non-negative and non-positive tests and fails the negative and positive tests.
- R8: `link_we_o` is high for every taken result except the jump without link, and low for every result that is not taken.
- R9: Reserved codes (`grp_i`=0 with `fn_i` 10..15, `grp_i`=1 with `fn_i` 6..15) give a result that is not taken, with no link write and no overflow clear. The unused comparison code 2'b11 satisfies none of the comparison jumps.
- R10: A request is answered in the next cycle with `rsp_vld_o` high. In a cycle that follows no request, `rsp_vld_o`, `taken_o`, `link_we_o` and `ovf_clr_o` are all low.
- R11: While `rst_ni` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_vld_i | input | 1 | A jump request is present this cycle |
| grp_i | input | 1 | 0: flag and status jumps, 1: register sign tests |
| fn_i | input | 4 | Jump function code within the group |
| reg_sel_i | input | 3 | Register examined by a sign test |
| ovf_i | input | 1 | Current overflow status |
| cmp_i | input | 2 | Current comparison status |
| acc_i | input | 31 | Accumulator, sign over 30-bit magnitude |
| ext_i | input | 31 | Extension register, sign over 30-bit magnitude |
| idx_i | input | 6x13 | Index registers 1..6, sign over 12-bit magnitude each |
| ea_i | input | 12 | Effective address, address field plus index |
| next_pc_i | input | 12 | Address of the following instruction |
| rsp_vld_o | output | 1 | Result for the previous cycle's request |
| taken_o | output | 1 | Jump taken |
| target_o | output | 12 | Jump target address |
| link_we_o | output | 1 | Load the link register |
| link_val_o | output | 12 | Value for the link register |
| ovf_clr_o | output | 1 | Clear the overflow status |

## Verification
The embedded properties watch the invariants on every cycle. A link write never happens without a taken jump, and the jump without link never writes. An overflow clear needs the overflow status set and one of the two overflow tests. The three-way sign class is always exactly one-hot, and minus zero in the accumulator classifies as zero. Idle cycles are quiet and each request gets exactly one answer. The directed scenarios are the only place where the truth table itself is shown. They sweep every comparison code against every comparison jump, every selectable register with positive, negative, plus-zero and minus-zero contents against all six sign tests, the two overflow tests in both overflow states, and the reserved codes.

// File: rtl/jcl_pkg.sv
package jcl_pkg;

  // Function codes of the flag and status group (grp = 0)
  typedef enum logic [3:0] {
    FN_JUMP   = 4'd0,
    FN_NOLINK = 4'd1,
    FN_OVF    = 4'd2,
    FN_NOOVF  = 4'd3,
    FN_LT     = 4'd4,
    FN_EQ     = 4'd5,
    FN_GT     = 4'd6,
    FN_GE     = 4'd7,
    FN_NE     = 4'd8,
    FN_LE     = 4'd9
  } flag_fn_e;

  // Function codes of the register test group (grp = 1)
  typedef enum logic [3:0] {
    RT_NEG  = 4'd0,
    RT_ZERO = 4'd1,
    RT_POS  = 4'd2,
    RT_NNEG = 4'd3,
    RT_NZER = 4'd4,
    RT_NPOS = 4'd5
  } reg_fn_e;

  // Comparison status encoding
  localparam logic [1:0] CMP_EQ = 2'b00;
  localparam logic [1:0] CMP_LT = 2'b01;
  localparam logic [1:0] CMP_GT = 2'b10;

  typedef struct packed {
    logic neg;
    logic zero;
    logic pos;
  } sgn_cls_t;

  typedef struct packed {
    logic take;
    logic link;
    logic oclr;
  } jdec_t;

endpackage

// File: rtl/jcl_regsel.sv
module jcl_regsel
  import jcl_pkg::*;
#(
  parameter int BYTE_W     = 6,
  parameter int WORD_BYTES = 5,
  parameter int IDX_BYTES  = 2,
  parameter int N_IDX      = 6,
  localparam int WMAG      = BYTE_W * WORD_BYTES,
  localparam int IMAG      = BYTE_W * IDX_BYTES,
  localparam int NSRC      = N_IDX + 2,
  localparam int SELW      = $clog2(NSRC)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [WMAG:0]              acc_i,
  input  logic [WMAG:0]              ext_i,
  input  logic [N_IDX-1:0][IMAG:0]   idx_i,
  input  logic [SELW-1:0]            sel_i,
  output sgn_cls_t                   cls_o
);

  logic [NSRC-1:0][WMAG-1:0] src_mag;
  logic [NSRC-1:0]           src_sgn;
  logic [WMAG-1:0]           pick_mag;
  logic                      pick_sgn;
  logic                      mag_zero;

  // Word-wide sources
  assign src_mag[0] = acc_i[WMAG-1:0];
  assign src_sgn[0] = acc_i[WMAG];
  assign src_mag[1] = ext_i[WMAG-1:0];
  assign src_sgn[1] = ext_i[WMAG];

  // Index registers widened to word magnitude
  for (genvar k = 0; k < N_IDX; k++) begin : g_idx
    assign src_mag[k+2] = {{(WMAG-IMAG){1'b0}}, idx_i[k][IMAG-1:0]};
    assign src_sgn[k+2] = idx_i[k][IMAG];
  end

  always_comb begin
    pick_mag = '0;
    pick_sgn = 1'b0;
    for (int s = 0; s < NSRC; s++) begin
      if (int'(sel_i) == s) begin
        pick_mag = src_mag[s];
        pick_sgn = src_sgn[s];
      end
    end
  end

  assign mag_zero = (pick_mag == '0);

  always_comb begin
    cls_o.zero = mag_zero;
    cls_o.neg  = pick_sgn  && !mag_zero;
    cls_o.pos  = !pick_sgn && !mag_zero;
  end

  // Exactly one sign class at all times
  p_cls_onehot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({cls_o.neg, cls_o.zero, cls_o.pos}) == 1);

  // Minus zero in the accumulator is zero, never negative
  p_minus_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == '0 && acc_i[WMAG-1:0] == '0) |-> (cls_o.zero && !cls_o.neg && !cls_o.pos));

endmodule

// File: rtl/jcl_decide.sv
module jcl_decide
  import jcl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       vld_i,
  input  logic       grp_i,
  input  logic [3:0] fn_i,
  input  logic       ovf_i,
  input  logic [1:0] cmp_i,
  input  sgn_cls_t   cls_i,
  output jdec_t      dec_o
);

  logic is_lt, is_eq, is_gt;
  logic flag_take, flag_oclr, reg_take;
  logic no_link;

  assign is_lt = (cmp_i == CMP_LT);
  assign is_eq = (cmp_i == CMP_EQ);
  assign is_gt = (cmp_i == CMP_GT);

  // Flag and status group
  always_comb begin
    flag_take = 1'b0;
    flag_oclr = 1'b0;
    case (fn_i)
      FN_JUMP:   flag_take = 1'b1;
      FN_NOLINK: flag_take = 1'b1;
      FN_OVF: begin
        flag_take = ovf_i;
        flag_oclr = ovf_i;
      end
      FN_NOOVF: begin
        flag_take = !ovf_i;
        flag_oclr = ovf_i;
      end
      FN_LT:   flag_take = is_lt;
      FN_EQ:   flag_take = is_eq;
      FN_GT:   flag_take = is_gt;
      FN_GE:   flag_take = is_gt || is_eq;
      FN_NE:   flag_take = is_lt || is_gt;
      FN_LE:   flag_take = is_lt || is_eq;
      default: flag_take = 1'b0;
    endcase
  end

  // Register sign test group
  always_comb begin
    case (fn_i)
      RT_NEG:  reg_take = cls_i.neg;
      RT_ZERO: reg_take = cls_i.zero;
      RT_POS:  reg_take = cls_i.pos;
      RT_NNEG: reg_take = !cls_i.neg;
      RT_NZER: reg_take = !cls_i.zero;
      RT_NPOS: reg_take = !cls_i.pos;
      default: reg_take = 1'b0;
    endcase
  end

  assign no_link = !grp_i && (fn_i == FN_NOLINK);

  always_comb begin
    dec_o.take = vld_i && (grp_i ? reg_take : flag_take);
    dec_o.oclr = vld_i && !grp_i && flag_oclr;
    dec_o.link = dec_o.take && !no_link;
  end

  p_nolink_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && !grp_i && fn_i == 4'd1) |-> !dec_o.link);

  p_clr_needs_ovf_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_o.oclr |-> (ovf_i && !grp_i && (fn_i == 4'd2 || fn_i == 4'd3)));

  p_cmp_keeps_ovf_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && !grp_i && fn_i >= 4'd4) |-> !dec_o.oclr);

  p_link_needs_take_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_o.link |-> dec_o.take);

endmodule

// File: rtl/jcl_outreg.sv
module jcl_outreg
  import jcl_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  jdec_t             dec_i,
  input  logic [ADDR_W-1:0] ea_i,
  input  logic [ADDR_W-1:0] next_pc_i,
  output logic              rsp_vld_o,
  output logic              taken_o,
  output logic [ADDR_W-1:0] target_o,
  output logic              link_we_o,
  output logic [ADDR_W-1:0] link_val_o,
  output logic              ovf_clr_o
);

  jdec_t             dec_q, dec_d;
  logic              vld_q, vld_d;
  logic [ADDR_W-1:0] tgt_q, lnk_q;

  always_comb begin
    vld_d = vld_i;
    dec_d = vld_i ? dec_i : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      dec_q <= '0;
    end else begin
      vld_q <= vld_d;
      dec_q <= dec_d;
    end
  end

  // Addresses load only with a request
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_q <= '0;
      lnk_q <= '0;
    end else if (vld_i) begin
      tgt_q <= ea_i;
      lnk_q <= next_pc_i;
    end
  end

  assign rsp_vld_o  = vld_q;
  assign taken_o    = dec_q.take;
  assign link_we_o  = dec_q.link;
  assign ovf_clr_o  = dec_q.oclr;
  assign target_o   = tgt_q;
  assign link_val_o = lnk_q;

  p_target_capture_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i |=> (target_o == $past(ea_i) && link_val_o == $past(next_pc_i)));

  p_answer_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i |=> rsp_vld_o);

  p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> (!rsp_vld_o && !taken_o && !link_we_o && !ovf_clr_o));

endmodule

// File: rtl/jmp_cond_link.sv
module jmp_cond_link
  import jcl_pkg::*;
#(
  parameter int BYTE_W     = 6,
  parameter int WORD_BYTES = 5,
  parameter int IDX_BYTES  = 2,
  parameter int ADDR_BYTES = 2,
  parameter int N_IDX      = 6,
  localparam int WMAG      = BYTE_W * WORD_BYTES,
  localparam int IMAG      = BYTE_W * IDX_BYTES,
  localparam int ADDR_W    = BYTE_W * ADDR_BYTES,
  localparam int SELW      = $clog2(N_IDX + 2)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_vld_i,
  input  logic                     grp_i,
  input  logic [3:0]               fn_i,
  input  logic [SELW-1:0]          reg_sel_i,
  input  logic                     ovf_i,
  input  logic [1:0]               cmp_i,
  input  logic [WMAG:0]            acc_i,
  input  logic [WMAG:0]            ext_i,
  input  logic [N_IDX-1:0][IMAG:0] idx_i,
  input  logic [ADDR_W-1:0]        ea_i,
  input  logic [ADDR_W-1:0]        next_pc_i,
  output logic                     rsp_vld_o,
  output logic                     taken_o,
  output logic [ADDR_W-1:0]        target_o,
  output logic                     link_we_o,
  output logic [ADDR_W-1:0]        link_val_o,
  output logic                     ovf_clr_o
);

  logic [1:0] rst_sync_q;
  logic       rst_n_int;
  sgn_cls_t   cls;
  jdec_t      dec;

  // Reset asserts at once, releases on the clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  jcl_regsel #(
    .BYTE_W(BYTE_W), .WORD_BYTES(WORD_BYTES),
    .IDX_BYTES(IDX_BYTES), .N_IDX(N_IDX)
  ) u_regsel (
    .clk_i (clk_i),
    .rst_ni(rst_n_int),
    .acc_i (acc_i),
    .ext_i (ext_i),
    .idx_i (idx_i),
    .sel_i (reg_sel_i),
    .cls_o (cls)
  );

  jcl_decide u_decide (
    .clk_i (clk_i),
    .rst_ni(rst_n_int),
    .vld_i (req_vld_i),
    .grp_i (grp_i),
    .fn_i  (fn_i),
    .ovf_i (ovf_i),
    .cmp_i (cmp_i),
    .cls_i (cls),
    .dec_o (dec)
  );

  jcl_outreg #(.ADDR_W(ADDR_W)) u_outreg (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_int),
    .vld_i     (req_vld_i),
    .dec_i     (dec),
    .ea_i      (ea_i),
    .next_pc_i (next_pc_i),
    .rsp_vld_o (rsp_vld_o),
    .taken_o   (taken_o),
    .target_o  (target_o),
    .link_we_o (link_we_o),
    .link_val_o(link_val_o),
    .ovf_clr_o (ovf_clr_o)
  );

endmodule

// File: tb/jmp_cond_link_tb.sv
`timescale 1ns/1ps
module jmp_cond_link_tb;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             req_vld, grp, ovf;
  logic [3:0]       fn;
  logic [2:0]       sel;
  logic [1:0]       cmp;
  logic [30:0]      acc, ext;
  logic [5:0][12:0] idx;
  logic [11:0]      ea, npc;
  logic             rsp_vld, taken, link_we, ovf_clr;
  logic [11:0]      target, link_val;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  jmp_cond_link u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_vld_i(req_vld), .grp_i(grp),
    .fn_i(fn), .reg_sel_i(sel), .ovf_i(ovf), .cmp_i(cmp),
    .acc_i(acc), .ext_i(ext), .idx_i(idx), .ea_i(ea), .next_pc_i(npc),
    .rsp_vld_o(rsp_vld), .taken_o(taken), .target_o(target),
    .link_we_o(link_we), .link_val_o(link_val), .ovf_clr_o(ovf_clr)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Expected {take, link, clear} from the requirement text
  function automatic logic [2:0] model(input logic g, input logic [3:0] f,
                                        input logic [2:0] s, input logic o,
                                        input logic [1:0] c);
    logic t, l, k, sg, n, z, p;
    logic [29:0] m;
    t = 1'b0; k = 1'b0;
    if (!g) begin
      unique case (f)
        4'd0, 4'd1: t = 1'b1;
        4'd2: begin t = o;  k = o; end
        4'd3: begin t = !o; k = o; end
        4'd4: t = (c == 2'b01);
        4'd5: t = (c == 2'b00);
        4'd6: t = (c == 2'b10);
        4'd7: t = (c == 2'b10) || (c == 2'b00);
        4'd8: t = (c == 2'b01) || (c == 2'b10);
        4'd9: t = (c == 2'b01) || (c == 2'b00);
        default: t = 1'b0;
      endcase
    end else begin
      if (s == 3'd0) begin sg = acc[30]; m = acc[29:0]; end
      else if (s == 3'd1) begin sg = ext[30]; m = ext[29:0]; end
      else begin sg = idx[s-2][12]; m = {18'd0, idx[s-2][11:0]}; end
      z = (m == 0); n = sg && !z; p = !sg && !z;
      unique case (f)
        4'd0: t = n;
        4'd1: t = z;
        4'd2: t = p;
        4'd3: t = !n;
        4'd4: t = !z;
        4'd5: t = !p;
        default: t = 1'b0;
      endcase
    end
    l = t && !(!g && f == 4'd1);
    return {t, l, k};
  endfunction

  task automatic run(input string tag, input logic g, input logic [3:0] f,
                     input logic [2:0] s, input logic o, input logic [1:0] c,
                     input logic [11:0] a, input logic [11:0] np);
    logic [2:0] e;
    grp = g; fn = f; sel = s; ovf = o; cmp = c; ea = a; npc = np;
    req_vld = 1'b1;
    e = model(g, f, s, o, c);
    @(posedge clk);
    @(negedge clk);
    req_vld = 1'b0;
    check(tag, "taken", {31'd0, taken}, {31'd0, e[2]});
    check("R8", "link_we", {31'd0, link_we}, {31'd0, e[1]});
    check(tag, "ovf_clr", {31'd0, ovf_clr}, {31'd0, e[0]});
    check("R10", "rsp_vld", {31'd0, rsp_vld}, 32'd1);
    if (e[2]) check(tag, "target", {20'd0, target}, {20'd0, a});
    if (e[1]) check("R8", "link_val", {20'd0, link_val}, {20'd0, np});
  endtask

  task automatic t_reset();
    check("R11", "rsp_vld", {31'd0, rsp_vld}, 32'd0);
    check("R11", "taken", {31'd0, taken}, 32'd0);
    check("R11", "link_we", {31'd0, link_we}, 32'd0);
    check("R11", "ovf_clr", {31'd0, ovf_clr}, 32'd0);
    check("R11", "target", {20'd0, target}, 32'd0);
    check("R11", "link_val", {20'd0, link_val}, 32'd0);
  endtask

  task automatic t_plain_jump();
    run("R1", 1'b0, 4'd0, 3'd0, 1'b0, 2'b00, 12'h123, 12'h045);
    run("R1", 1'b0, 4'd0, 3'd0, 1'b1, 2'b11, 12'hFFF, 12'h000);
    run("R1", 1'b0, 4'd0, 3'd0, 1'b0, 2'b10, 12'h000, 12'hFFF);
  endtask

  task automatic t_no_link();
    run("R2", 1'b0, 4'd1, 3'd0, 1'b0, 2'b00, 12'h2A5, 12'h111);
    run("R2", 1'b0, 4'd1, 3'd0, 1'b1, 2'b01, 12'h5A2, 12'h222);
  endtask

  task automatic t_ovf_jumps();
    run("R3", 1'b0, 4'd2, 3'd0, 1'b1, 2'b00, 12'h300, 12'h301);
    run("R3", 1'b0, 4'd2, 3'd0, 1'b0, 2'b00, 12'h310, 12'h311);
    run("R4", 1'b0, 4'd3, 3'd0, 1'b0, 2'b00, 12'h320, 12'h321);
    run("R4", 1'b0, 4'd3, 3'd0, 1'b1, 2'b00, 12'h330, 12'h331);
  endtask

  task automatic t_compare();
    for (int f = 4; f <= 9; f++)
      for (int c = 0; c < 4; c++)
        run((c == 3) ? "R9" : "R5", 1'b0, 4'(f), 3'd0, 1'b1, 2'(c),
            12'(16 * f + c), 12'(f + 100));
  endtask

  task automatic t_reg_tests();
    for (int v = 0; v < 4; v++) begin
      // v: 0 positive, 1 negative, 2 plus zero, 3 minus zero
      logic sg;
      sg = (v == 1) || (v == 3);
      acc = {sg, (v < 2) ? 30'h2000_0001 : 30'd0};
      ext = {sg, (v < 2) ? 30'd7 : 30'd0};
      for (int k = 0; k < 6; k++)
        idx[k] = {sg, (v < 2) ? 12'(k + 1) : 12'd0};
      for (int s = 0; s < 8; s++)
        for (int f = 0; f < 6; f++)
          run((v == 3) ? "R7" : "R6", 1'b1, 4'(f), 3'(s), 1'b1, 2'b00,
              12'(s * 64 + f), 12'(v * 8 + s));
    end
    // Only the chosen register decides: accumulator negative, rest positive
    acc = {1'b1, 30'd5}; ext = {1'b0, 30'd5};
    for (int k = 0; k < 6; k++) idx[k] = {1'b0, 12'd9};
    run("R6", 1'b1, 4'd0, 3'd0, 1'b0, 2'b00, 12'h700, 12'h701);
    run("R6", 1'b1, 4'd0, 3'd1, 1'b0, 2'b00, 12'h710, 12'h711);
    run("R6", 1'b1, 4'd2, 3'd7, 1'b0, 2'b00, 12'h720, 12'h721);
  endtask

  task automatic t_reserved();
    for (int f = 10; f < 16; f++)
      run("R9", 1'b0, 4'(f), 3'd0, 1'b1, 2'b00, 12'h400, 12'h401);
    for (int f = 6; f < 16; f++)
      run("R9", 1'b1, 4'(f), 3'd2, 1'b1, 2'b00, 12'h410, 12'h411);
  endtask

  task automatic t_idle();
    run("R3", 1'b0, 4'd2, 3'd0, 1'b1, 2'b00, 12'h500, 12'h501);
    @(posedge clk);
    @(negedge clk);
    check("R10", "idle rsp_vld", {31'd0, rsp_vld}, 32'd0);
    check("R10", "idle taken", {31'd0, taken}, 32'd0);
    check("R10", "idle link_we", {31'd0, link_we}, 32'd0);
    check("R10", "idle ovf_clr", {31'd0, ovf_clr}, 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; req_vld = 1'b0; grp = 1'b0; fn = 4'd0; sel = 3'd0;
    ovf = 1'b0; cmp = 2'b00; acc = '0; ext = '0; idx = '0; ea = '0; npc = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_plain_jump();
    t_no_link();
    t_ovf_jumps();
    t_compare();
    t_reg_tests();
    t_reserved();
    t_idle();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule